// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck with SDA held low. It watches synchronised copies of the SCL and SDA line levels and reports them as status bits, together with a bus-busy flag. When software issues a recover strobe, the block pulls SCL low and releases it in a train of clock pulses. It uses ticks from the shared SCL timing generator to pace the low and high phases. After each pulse it looks at SDA, and it stops as soon as the target has let go of the line.

At least one pulse is always emitted and at most `MAX_PULSES` (eight by default). Completion is always flagged by a one-cycle recovery-done pulse. This holds whether SDA came free or the pulse budget ran out. Software tells the two outcomes apart by reading the SDA status bit afterwards. If both lines already read high, the bus is idle and software has no need to start a recovery.

Top module: `i2c_bus_recover`

## Requirements
- R1: While reset is asserted and right after it, `sclDriveLow` and `recoverDone` are 0, `sclLevel` and `sdaLevel` read 1 and `busBusy` is 0.
- R2: `sclLevel` follows `sclIn` and `sdaLevel` follows `sdaIn`, each delayed by exactly `SYNC_STAGES` (default 2) clock edges.
- R3: `busBusy` is 1 whenever `sclLevel` or `sdaLevel` is 0 or a recovery is in progress. It is 0 only when both levels are 1 and the sequencer is idle.
- R4: A `recoverCmd` seen while idle sets `sclDriveLow` to 1 on the following clock edge. Each pulse holds SCL low until the next `sclTick`, then releases it until the tick after that.
- R5: SDA is examined on the tick that ends each high phase. If it reads high, the sequence ends there and no further pulse starts.
- R6: Every recovery emits at least 1 and at most `MAX_PULSES` (default 8) pulses. A target that releases SDA during pulse N (N ≤ 8) gets exactly N pulses, or 1 pulse if SDA was already high.
- R7: Every recovery ends with `recoverDone` high for exactly one cycle, on the edge after the final tick. If the limit is reached with SDA still low, `recoverDone` still fires and `sdaLevel` reads 0 at that moment.
- R8: A `recoverCmd` that arrives while a recovery is running has no effect: the pulse count and the single `recoverDone` of that run are unchanged.
- R9: `sclTick` has no effect while the sequencer is idle: `sclDriveLow` stays 0 and no `recoverDone` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recoverCmd | input | 1 | One-cycle strobe that starts a recovery |
| sclIn | input | 1 | Raw SCL line sample |
| sdaIn | input | 1 | Raw SDA line sample |
| sclTick | input | 1 | Phase tick from the SCL timing generator |
| sclDriveLow | output | 1 | 1 pulls SCL low (open-drain enable) |
| sclLevel | output | 1 | Synchronised SCL level |
| sdaLevel | output | 1 | Synchronised SDA level |
| busBusy | output | 1 | Bus not idle, or recovery running |
| recoverDone | output | 1 | One-cycle recovery-complete interrupt pulse |

## Verification
The hardest case to reach from the ports is a target that lets SDA go at exactly the eighth pulse. Here the SDA check and the pulse limit fall on the same tick, and the run must still count as a success. A second hard case is a redundant command that lands in the middle of a running sequence. The bench models the target as a counter of completed SCL low phases that releases SDA after a chosen number of them. It sweeps that number over 0, 3, 5, 8 and 12, and in the run with 5 it issues a second command a few cycles after the first.

// File: rtl/recover_pkg.sv
package recover_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LOW,
    SEQ_HIGH
  } seqState_t;

  // Strobes from the sequence control to the datapath.
  typedef struct packed {
    logic countLoad;    // start a new pulse count at one
    logic countInc;     // one more pulse begins
    logic driveAssert;  // pull SCL low
    logic driveRelease; // let SCL float high
    logic doneFire;     // raise the completion pulse next cycle
  } seqStrobes_t;

endpackage

// File: rtl/recover_datapath.sv
module recover_datapath
  import recover_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_PULSES  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  seqStrobes_t strobes,
  output logic        sclSync,
  output logic        sdaSync,
  output logic        countAtMax,
  output logic        sclDriveLow,
  output logic        recoverDone
);

  localparam int CNT_W = $clog2(MAX_PULSES + 1);
  localparam logic [CNT_W-1:0] COUNT_LIMIT = CNT_W'(MAX_PULSES);

  // Line synchronisers, bit 1 = SCL, bit 0 = SDA; idle-high reset value.
  logic [1:0] syncChain [SYNC_STAGES];

  for (genvar stage = 0; stage < SYNC_STAGES; stage++) begin : g_sync
    if (stage == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain[stage] <= 2'b11;
        else        syncChain[stage] <= {sclIn, sdaIn};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain[stage] <= 2'b11;
        else        syncChain[stage] <= syncChain[stage-1];
      end
    end
  end

  assign sclSync = syncChain[SYNC_STAGES-1][1];
  assign sdaSync = syncChain[SYNC_STAGES-1][0];

  // Pulse counter.
  logic [CNT_W-1:0] pulseCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseCount <= '0;
    end else if (strobes.countLoad) begin
      pulseCount <= CNT_W'(1);
    end else if (strobes.countInc) begin
      pulseCount <= pulseCount + CNT_W'(1);
    end
  end

  assign countAtMax = (pulseCount >= COUNT_LIMIT);

  // SCL drive enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclDriveLow <= 1'b0;
    end else if (strobes.driveAssert) begin
      sclDriveLow <= 1'b1;
    end else if (strobes.driveRelease) begin
      sclDriveLow <= 1'b0;
    end
  end

  // Completion pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recoverDone <= 1'b0;
    else        recoverDone <= strobes.doneFire;
  end

endmodule

// File: rtl/recover_ctrl.sv
module recover_ctrl
  import recover_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        recoverCmd,
  input  logic        sclTick,
  input  logic        sdaReleased,
  input  logic        countAtMax,
  output seqStrobes_t strobes,
  output logic        seqActive
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      SEQ_IDLE: begin
        // Ticks are meaningless here; only a command starts work.
        if (recoverCmd) begin
          strobes.countLoad   = 1'b1;
          strobes.driveAssert = 1'b1;
          stateNext           = SEQ_LOW;
        end
      end
      SEQ_LOW: begin
        if (sclTick) begin
          strobes.driveRelease = 1'b1;
          stateNext            = SEQ_HIGH;
        end
      end
      SEQ_HIGH: begin
        if (sclTick) begin
          if (sdaReleased || countAtMax) begin
            strobes.doneFire = 1'b1;
            stateNext        = SEQ_IDLE;
          end else begin
            strobes.countInc    = 1'b1;
            strobes.driveAssert = 1'b1;
            stateNext           = SEQ_LOW;
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  assign seqActive = (state != SEQ_IDLE);

endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import recover_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_PULSES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recoverCmd,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic sclTick,
  output logic sclDriveLow,
  output logic sclLevel,
  output logic sdaLevel,
  output logic busBusy,
  output logic recoverDone
);

  seqStrobes_t strobes;
  logic        sclSync;
  logic        sdaSync;
  logic        countAtMax;
  logic        seqActive;

  recover_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .recoverCmd  (recoverCmd),
    .sclTick     (sclTick),
    .sdaReleased (sdaSync),
    .countAtMax  (countAtMax),
    .strobes     (strobes),
    .seqActive   (seqActive)
  );

  recover_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .MAX_PULSES  (MAX_PULSES)
  ) i_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .strobes     (strobes),
    .sclSync     (sclSync),
    .sdaSync     (sdaSync),
    .countAtMax  (countAtMax),
    .sclDriveLow (sclDriveLow),
    .recoverDone (recoverDone)
  );

  assign sclLevel = sclSync;
  assign sdaLevel = sdaSync;
  assign busBusy  = seqActive | ~(sclSync & sdaSync);

endmodule

// File: rtl/i2c_bus_recover_checker.sv
module i2c_bus_recover_checker #(
  parameter int MAX_PULSES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sclTick,
  input logic sclDriveLow,
  input logic busBusy,
  input logic recoverDone
);

  localparam int SEEN_W = $clog2(MAX_PULSES + 2);

  logic [SEEN_W-1:0] pulseSeen;
  logic              drivePrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseSeen <= '0;
      drivePrev <= 1'b0;
    end else begin
      drivePrev <= sclDriveLow;
      if (recoverDone) pulseSeen <= '0;
      else if (sclDriveLow && !drivePrev) pulseSeen <= pulseSeen + SEEN_W'(1);
    end
  end

  // R7: the completion pulse lasts one cycle.
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recoverDone |=> !recoverDone);

  // R5: completion only follows a phase tick, with SCL released.
  assert_done_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recoverDone) |-> ($past(sclTick) && !sclDriveLow));

  // R4: a low phase lasts until the next tick.
  assert_low_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclDriveLow && !sclTick) |=> sclDriveLow);

  // R3: driving SCL implies the bus reports busy.
  assert_busy_when_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclDriveLow |-> busBusy);

  // R6: pulse budget upper bound.
  assert_pulse_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulseSeen <= SEEN_W'(MAX_PULSES));

  // R6: at least one pulse before completion.
  assert_min_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recoverDone |-> (pulseSeen >= SEEN_W'(1)));

endmodule

bind i2c_bus_recover i2c_bus_recover_checker #(
  .MAX_PULSES (MAX_PULSES)
) i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclTick     (sclTick),
  .sclDriveLow (sclDriveLow),
  .busBusy     (busBusy),
  .recoverDone (recoverDone)
);

// File: tb/test_i2c_bus_recover.sv
`timescale 1ns/1ps
module test_i2c_bus_recover;

  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recoverCmd = 1'b0;
  logic sclStuck = 1'b0;
  logic sdaIn = 1'b1;
  logic sclTick = 1'b0;
  logic sclIn;
  logic sclDriveLow, sclLevel, sdaLevel, busBusy, recoverDone;

  int checkCount = 0;
  int failCount = 0;
  int doneCount = 0;
  int relTarget = 0;
  int pulseCnt = 0;
  int fallCnt = 0;
  int tickCnt = 0;
  logic prevDrive = 1'b0;
  logic prevDone = 1'b0;
  bit finished = 1'b0;

  int expPulses[$];
  bit expSda[$];

  always #2 clk = ~clk;

  // Open-drain bus model: SCL is low if the block or a stuck device pulls it.
  assign sclIn = ~(sclDriveLow | sclStuck);

  i2c_bus_recover #(.SYNC_STAGES(2), .MAX_PULSES(MAXP)) i_i2c_bus_recover (
    .clk(clk), .rst_n(rst_n), .recoverCmd(recoverCmd), .sclIn(sclIn),
    .sdaIn(sdaIn), .sclTick(sclTick), .sclDriveLow(sclDriveLow),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .busBusy(busBusy),
    .recoverDone(recoverDone)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  // Tick generator, target model and scoreboard monitor, all off the active edge.
  always @(negedge clk) begin
    tickCnt = (tickCnt + 1) % 8;
    sclTick <= (tickCnt == 7);
    if (sclDriveLow && !prevDrive) pulseCnt++;
    if (!sclDriveLow && prevDrive) fallCnt++;
    if (recoverDone) begin
      check(!prevDone, "R7 done width", 2, 1);
      if (expPulses.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        int ep;
        bit es;
        ep = expPulses.pop_front();
        es = expSda.pop_front();
        check(pulseCnt == ep, "R6 pulse count", pulseCnt, ep);
        check(sdaLevel == es, "R7 sda status at done", sdaLevel, es);
      end
      doneCount++;
      pulseCnt = 0;
      fallCnt = 0;
    end
    sdaIn <= (fallCnt >= relTarget);
    prevDrive = sclDriveLow;
    prevDone = recoverDone;
  end

  task automatic runRecovery(int rel, bit dupCmd, bit busyProbe);
    int startDone;
    int ep;
    relTarget = rel;
    repeat (4) @(negedge clk);
    ep = (rel < 1) ? 1 : ((rel > MAXP) ? MAXP : rel);
    expPulses.push_back(ep);
    expSda.push_back(rel <= MAXP);
    startDone = doneCount;
    recoverCmd = 1'b1;
    @(negedge clk);
    recoverCmd = 1'b0;
    check(sclDriveLow == 1'b1, "R4 drive after command", sclDriveLow, 1);
    if (dupCmd) begin
      repeat (3) @(negedge clk);
      recoverCmd = 1'b1;
      @(negedge clk);
      recoverCmd = 1'b0;
    end
    if (busyProbe) begin
      for (int i = 0; i < 20 && sclDriveLow; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      check(busBusy == 1'b1, "R3 busy while active, lines high", busBusy, 1);
      check(sclLevel && sdaLevel, "R3 lines high in high phase", {sclLevel, sdaLevel}, 3);
    end
    for (int i = 0; i < 400 && doneCount == startDone; i++) @(negedge clk);
    check(doneCount == startDone + 1, "R7 done reached", doneCount - startDone, 1);
    repeat (40) @(negedge clk);
    check(doneCount == startDone + 1, "R8 single done per run", doneCount - startDone, 1);
    check(sclDriveLow == 1'b0, "R5 no pulse after end", sclDriveLow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclDriveLow == 0 && recoverDone == 0, "R1 outputs in reset", {sclDriveLow, recoverDone}, 0);
    check(sclLevel && sdaLevel && !busBusy, "R1 status in reset", {sclLevel, sdaLevel, busBusy}, 6);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclDriveLow == 0 && !busBusy, "R1 after reset", {sclDriveLow, busBusy}, 0);

    // R9: ticks while idle do nothing
    repeat (30) @(negedge clk);
    check(sclDriveLow == 0, "R9 idle ticks drive", sclDriveLow, 0);
    check(doneCount == 0, "R9 idle ticks done", doneCount, 0);

    // R2/R3: synchroniser latency and busy from line levels
    sclStuck = 1'b1;
    @(negedge clk);
    check(sclLevel == 1'b1, "R2 scl before latency", sclLevel, 1);
    @(negedge clk);
    check(sclLevel == 1'b0, "R2 scl after latency", sclLevel, 0);
    check(busBusy == 1'b1, "R3 busy with scl low", busBusy, 1);
    sclStuck = 1'b0;
    relTarget = 100;
    repeat (3) @(negedge clk);
    check(sdaLevel == 1'b0 && sclLevel == 1'b1, "R2 sda low seen", {sclLevel, sdaLevel}, 2);
    check(busBusy == 1'b1, "R3 busy with sda low", busBusy, 1);
    relTarget = 0;
    repeat (3) @(negedge clk);
    check(busBusy == 1'b0, "R3 idle when both high", busBusy, 0);

    // R6: SDA already free -> one pulse; busy during active phase
    runRecovery(0, 1'b0, 1'b1);
    // R5: release mid-sequence
    runRecovery(3, 1'b0, 1'b0);
    // R8: second command mid-run ignored
    runRecovery(5, 1'b1, 1'b0);
    // R6: release exactly at the limit
    runRecovery(8, 1'b0, 1'b0);
    // R7: exhaustion, SDA stays low
    runRecovery(12, 1'b0, 1'b0);
    check(sdaLevel == 1'b0, "R7 sda low after exhaustion", sdaLevel, 0);
    check(expPulses.size() == 0, "R6 all runs completed", expPulses.size(), 0);

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

endmodule